// File: doc/BRIEF.md
# Recursive Quadrature Sine/Cosine Oscillator

This block produces a sine word and a cosine word on every enabled clock without any table or iterative rotation. It keeps the current sine/cosine pair in two registers. Each update takes the partner value, scales it by a signed frequency word, and adds the result to sine or subtracts it from cosine. The step angle per clock is about 2π·f/fclk, so the frequency word sets the tone directly.

A load strobe seeds the pair to cosine = 1.0 and sine = 0 and starts the run. Valid rises on the next cycle, and the outputs then show sample 0. Each later enabled cycle advances the pair by one step. Holding the enable low freezes the pair. Synchronous reset returns the pair to the seed and clears valid. The update is forward-difference with no second-order correction, so the amplitude grows slowly. For small step angles this growth stays bounded over thousands of samples.

Top module: `quad_osc`

## Requirements
- R1: With the synchronous reset `rst` high at a rising edge, the next outputs are cos_o = 32'h4000_0000, sin_o = 0 and vld = 0, whatever the other inputs are.
- R2: While vld is low and load is low, both outputs stay at the seed values (cos 32'h4000_0000, sin 0) and vld stays low, whatever en and fcw are.
- R3: load high at an edge (reset low) sets the outputs to the seed values and vld to 1 on the next cycle. This holds even when en is low and when a run is already in progress.
- R4: At an edge with vld = 1, en = 1, load = 0 and rst = 0, the new sine is old sine + P(fcw, old cosine), and the new cosine is old cosine − P(fcw, old sine). Both use the values from before the edge. The add and subtract wrap at 32 bits.
- R5: P(a, b) takes the full signed 64-bit product a·b, adds 2^29, shifts right arithmetically by 30, and keeps the low 32 bits (round half up).
- R6: fcw, sin_o and cos_o are signed two's complement Q2.30 words, so 1.0 is 32'h4000_0000.
- R7: At an edge with vld = 1, en = 0, load = 0 and rst = 0, both outputs keep their values.
- R8: With fcw ≈ 2π/1024·2^30 and en held high after a load, sample n stays within 0.002 + n·dθ² of sin(n·dθ) and cos(n·dθ) for n up to 1200, where dθ = fcw/2^30.
- R9: Once set, vld stays high until a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the seed state |
| load | input | 1 | Strobe that seeds the pair and starts the run |
| en | input | 1 | Advance enable; low holds the pair |
| fcw | input | 32 | Signed Q2.30 step angle in radians per clock |
| sin_o | output | 32 | Signed Q2.30 sine sample |
| cos_o | output | 32 | Signed Q2.30 cosine sample |
| vld | output | 1 | High from the cycle after a load until reset |

## Verification
Every result of this block comes from one register stage. The outputs after a rising edge depend only on the state and the inputs sampled at that edge. The driver sets the inputs half a period before an edge and predicts that edge's outcome from the requirements. It queues the prediction, and the monitor pops it one time unit after the same edge. In this way a seed, a hold, a reset or a step is compared exactly in the cycle it becomes visible. During the long tone runs, the same popped sample is also compared with the ideal sine and cosine of n·dθ.

// File: rtl/quad_osc_pkg.sv
package quad_osc_pkg;

    localparam int OSC_W    = 32;
    localparam int OSC_FRAC = 30;
    localparam int OSC_LANES = 2;   // lane 0 = sine, lane 1 = cosine

    typedef enum logic [1:0] {
        SEL_HOLD = 2'd0,
        SEL_STEP = 2'd1,
        SEL_SEED = 2'd2
    } osc_sel_e;

    function automatic osc_sel_e pick_sel(input logic ld, input logic running, input logic adv);
        if (ld)
            return SEL_SEED;
        else if (running && adv)
            return SEL_STEP;
        else
            return SEL_HOLD;
    endfunction

endpackage

// File: rtl/osc_round_mul.sv
module osc_round_mul #(
    parameter int W    = 32,
    parameter int FRAC = 30
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] p
);
    localparam int PW = 2 * W;
    localparam logic [PW-1:0] HALF = {{(PW-1){1'b0}}, 1'b1} << (FRAC - 1);

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] full;
    logic signed [PW-1:0] biased;
    logic [FRAC-1:0]      unused_low;
    logic [PW-W-FRAC-1:0] unused_high;

    assign a_ext  = {{W{a[W-1]}}, a};
    assign b_ext  = {{W{b[W-1]}}, b};
    assign full   = a_ext * b_ext;
    assign biased = full + $signed(HALF);
    assign p      = biased[FRAC+W-1:FRAC];

    assign unused_low  = biased[FRAC-1:0];
    assign unused_high = biased[PW-1:FRAC+W];
endmodule

// File: rtl/osc_seed_mux.sv
module osc_seed_mux
    import quad_osc_pkg::*;
#(
    parameter int W = 32
) (
    input  osc_sel_e            sel,
    input  logic signed [W-1:0] seed,
    input  logic signed [W-1:0] stepped,
    input  logic signed [W-1:0] held,
    output logic signed [W-1:0] y
);
    always_comb begin
        unique case (sel)
            SEL_SEED: y = seed;
            SEL_STEP: y = stepped;
            default:  y = held;
        endcase
    end
endmodule

// File: rtl/quad_osc.sv
module quad_osc
    import quad_osc_pkg::*;
#(
    parameter int W    = OSC_W,
    parameter int FRAC = OSC_FRAC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                en,
    input  logic signed [W-1:0] fcw,
    output logic signed [W-1:0] sin_o,
    output logic signed [W-1:0] cos_o,
    output logic                vld
);
    localparam logic signed [W-1:0] ONE  = {{(W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};
    localparam logic signed [W-1:0] ZERO = '0;

    osc_sel_e            sel;
    logic                vld_q;
    logic signed [W-1:0] st   [OSC_LANES];
    logic signed [W-1:0] prod [OSC_LANES];

    assign sel = pick_sel(load, vld_q, en);

    for (genvar g = 0; g < OSC_LANES; g++) begin : g_lane
        localparam logic signed [W-1:0] SEED = (g == 0) ? ZERO : ONE;
        logic signed [W-1:0] pr;
        logic signed [W-1:0] nxt;
        logic signed [W-1:0] muxed;
        logic signed [W-1:0] st_q;

        osc_round_mul #(.W(W), .FRAC(FRAC)) u_mul (
            .a (fcw),
            .b (st[OSC_LANES-1-g]),
            .p (pr)
        );

        if (g == 0) begin : g_add
            assign nxt = st_q + pr;
        end else begin : g_sub
            assign nxt = st_q - pr;
        end

        osc_seed_mux #(.W(W)) u_mux (
            .sel     (sel),
            .seed    (SEED),
            .stepped (nxt),
            .held    (st_q),
            .y       (muxed)
        );

        always_ff @(posedge clk) begin
            if (rst)
                st_q <= SEED;
            else
                st_q <= muxed;
        end

        assign st[g]   = st_q;
        assign prod[g] = pr;
    end

    always_ff @(posedge clk) begin
        if (rst)
            vld_q <= 1'b0;
        else if (load)
            vld_q <= 1'b1;
    end

    assign sin_o = st[0];
    assign cos_o = st[1];
    assign vld   = vld_q;

    AST_RESET_SEED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!vld && sin_o == ZERO && cos_o == ONE)); // R1
    AST_IDLE_SEED: assert property (@(posedge clk) disable iff (rst)
        (!vld && !load) |=> (!vld && sin_o == ZERO && cos_o == ONE)); // R2
    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (rst)
        load |=> (vld && sin_o == ZERO && cos_o == ONE)); // R3
    AST_SIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (vld && en && !load) |=> sin_o == $past(sin_o) + $past(prod[0])); // R4
    AST_COS_STEP: assert property (@(posedge clk) disable iff (rst)
        (vld && en && !load) |=> cos_o == $past(cos_o) - $past(prod[1])); // R4
    AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (rst)
        (vld && !en && !load) |=> ($stable(sin_o) && $stable(cos_o))); // R7
    AST_VALID_KEEP: assert property (@(posedge clk) disable iff (rst)
        vld |=> vld); // R9
endmodule

// File: tb/tb_quad_osc.sv
module tb_quad_osc;

    localparam logic signed [31:0] ONE_Q = 32'sh4000_0000;
    localparam real TWO_PI = 6.283185307179586;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               load = 1'b0;
    logic               en = 1'b0;
    logic signed [31:0] fcw = '0;
    logic signed [31:0] sin_o;
    logic signed [31:0] cos_o;
    logic               vld;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic signed [31:0] s;
        logic signed [31:0] c;
        logic               v;
        int                 n;
        real                dth;
        string              req;
    } exp_t;

    exp_t q[$];

    logic signed [31:0] m_s = 32'sd0;
    logic signed [31:0] m_c = ONE_Q;
    logic               m_v = 1'b0;

    always #4 clk = ~clk;

    quad_osc dut (
        .clk(clk), .rst(rst), .load(load), .en(en), .fcw(fcw),
        .sin_o(sin_o), .cos_o(cos_o), .vld(vld)
    );

    // R5 rounding rule, written from the requirement
    function automatic logic signed [31:0] rmul(input logic signed [31:0] a, input logic signed [31:0] b);
        longint full;
        longint sh;
        full = longint'(a) * longint'(b);
        sh = (full + 64'sd536870912) >>> 30;
        return sh[31:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%s expected=%s", req, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic ld, input logic e, input logic signed [31:0] f,
                        input string req, input int n);
        exp_t it;
        logic signed [31:0] ns;
        logic signed [31:0] nc;
        @(negedge clk);
        rst = r; load = ld; en = e; fcw = f;
        if (r) begin
            ns = 0; nc = ONE_Q; m_v = 1'b0;
        end else if (ld) begin
            ns = 0; nc = ONE_Q; m_v = 1'b1;
        end else if (m_v && e) begin
            ns = m_s + rmul(f, m_c);
            nc = m_c - rmul(f, m_s);
        end else begin
            ns = m_s; nc = m_c;
        end
        m_s = ns; m_c = nc;
        it.s = ns; it.c = nc; it.v = m_v; it.n = n;
        it.dth = $itor(f) / 1073741824.0;
        it.req = req;
        q.push_back(it);
    endtask

    // monitor: compares one queued prediction per edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                check(vld === it.v, it.req, "vld", $sformatf("%0b", vld), $sformatf("%0b", it.v));
                check(sin_o === it.s, it.req, "sin", $sformatf("%0d", sin_o), $sformatf("%0d", it.s));
                check(cos_o === it.c, it.req, "cos", $sformatf("%0d", cos_o), $sformatf("%0d", it.c));
                if (it.n >= 0) begin
                    real ang;
                    real tol;
                    real ds;
                    real dc;
                    ang = it.n * it.dth;
                    tol = 0.002 + it.n * it.dth * it.dth;
                    ds = $itor(sin_o) / 1073741824.0 - $sin(ang);
                    dc = $itor(cos_o) / 1073741824.0 - $cos(ang);
                    if (ds < 0.0) ds = -ds;
                    if (dc < 0.0) dc = -dc;
                    check(ds <= tol, "R8", "sine vs ideal",
                          $sformatf("%f", $itor(sin_o) / 1073741824.0), $sformatf("%f", $sin(ang)));
                    check(dc <= tol, "R8", "cosine vs ideal",
                          $sformatf("%f", $itor(cos_o) / 1073741824.0), $sformatf("%f", $cos(ang)));
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic signed [31:0] f_tone;
        f_tone = 32'(longint'(TWO_PI / 1024.0 * 1073741824.0 + 0.5));

        // R1: reset state, R6 seed encoding
        for (int i = 0; i < 3; i++) step(1, 0, 1, f_tone, "R1,R6", -1);
        // R2: no load yet, en high must not move anything
        for (int i = 0; i < 4; i++) step(0, 0, 1, f_tone, "R2", -1);
        // R3: load with en low still seeds and sets vld
        step(0, 1, 0, f_tone, "R3", -1);
        // R4, R5, R8: long tone run
        for (int n = 1; n <= 1200; n++) step(0, 0, 1, f_tone, "R4,R5,R8", n);
        // R7: enable low holds; R9 vld stays
        for (int i = 0; i < 5; i++) step(0, 0, 0, f_tone, "R7,R9", -1);
        for (int i = 0; i < 20; i++) step(0, 0, 1, f_tone, "R4", -1);
        // R3: reload during a run with en high
        step(0, 1, 1, f_tone, "R3", -1);
        // R4, R8: negative frequency word
        for (int n = 1; n <= 300; n++) step(0, 0, 1, -f_tone, "R4,R8", n);
        // R5, R6: large step word 0.5 exercises rounding and sign handling
        step(0, 1, 1, 32'sh2000_0000, "R3", -1);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 32'sh2000_0000, "R5,R6", -1);
        // R5: odd step word so products land on rounding boundaries
        step(0, 1, 1, 32'sh0000_8001, "R3", -1);
        for (int i = 0; i < 40; i++) step(0, 0, 1, 32'sh0000_8001, "R5", -1);
        // R1 mid-run reset, then R2 idle with en high
        step(1, 0, 1, f_tone, "R1", -1);
        for (int i = 0; i < 3; i++) step(0, 0, 1, f_tone, "R2", -1);
        // R9: vld persists across a long hold
        step(0, 1, 0, f_tone, "R3", -1);
        for (int i = 0; i < 10; i++) step(0, 0, 0, 32'sh1234_5678, "R7,R9", -1);

        @(negedge clk);
        load = 1'b0; en = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule